// File: doc/BRIEF.md
# ATA PIO Cycle Timing Generator

This block produces the host-side strobe sequence for programmed-I/O register and data transfers on one parallel ATA channel. Every transfer passes through three timed phases. In the setup phase the address and the select line are valid and no strobe is asserted. In the active phase the read or the write strobe is low. In the recovery phase the strobe is released and the next transfer is held off. The length of each phase is a clock count held in a small register file.

The channel has one setup count, which both drives share. Each of the two drives also has its own timing byte, which holds that drive's active count and recovery count. Every count field uses a wrap encoding: a zero in the field stands for the largest count the field can express. Software derives each count from a nanosecond figure by rounding up to whole clocks. A request carries a drive number, and that number selects the timing byte used for the transfer.

The host side has a simple valid/ready request port and a register write port. A one-clock done pulse closes every transfer. For reads, the sampled data appears on `rd_data`.

Top module: `ata_pio_timer`

## Requirements
- R1: The setup phase lasts the number of clocks in the setup register (configuration address 0, bits [2:0]). A value of 0 means 8 clocks. During setup `ata_sel_n` is low and both strobes are high.
- R2: The active phase lasts the number of clocks in bits [6:4] of the selected drive's timing byte. A value of 0 means 8 clocks. During active `ata_sel_n` is low and exactly one strobe is low: `ata_wr_n` for a write, `ata_rd_n` for a read.
- R3: The recovery phase lasts the number of clocks in bits [3:0] of the selected drive's timing byte. A value of 0 means 16 clocks. During recovery both strobes and `ata_sel_n` are high, `ata_dout_en` is low, and `ata_addr` still holds the request address.
- R4: Configuration address 1 holds drive 0's timing byte and address 2 holds drive 1's. `req_drive` selects which byte times the active and recovery phases. Both drives use the same setup value.
- R5: `req_ready` is high only while no transfer is in progress. A transfer starts on a clock edge where `req_valid` and `req_ready` are both high. Setup begins on the next clock, and `req_ready` stays low until the transfer ends.
- R6: `done` is high for exactly one clock. That clock is the one right after the last recovery clock, and in it `req_ready` is high again.
- R7: For a write, `ata_dout_en` is high and `ata_dout` equals the request's `req_wdata` from the first setup clock to the last active clock. `req_wdata` may change after acceptance without effect.
- R8: For a read, `rd_data` takes the value of `ata_din` on the last active clock and holds it after `done`.
- R9: A configuration write made while a transfer is in progress leaves that transfer's phase lengths unchanged. It applies to the next transfer.
- R10: After reset every count field is 0, so a transfer runs 8 setup, 8 active and 16 recovery clocks. All outputs are inactive: strobes and select high, `done` and `ata_dout_en` low, `req_ready` high.
- R11: Counts derived by rounding up time × 33 MHz are written as follows. Setup or active values of 8 or more are written as 0. Recovery is written as cycle clocks minus the written active and setup values, with 0 forced to 1 and 16 or more written as 0. For the five standard PIO timing sets, these counts produce the expected phase lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 setup, 1 drive 0 timing, 2 drive 1 timing |
| cfg_wdata | input | 7 | Register write data |
| req_valid | input | 1 | Transfer request |
| req_ready | output | 1 | Block is idle and can accept a request |
| req_write | input | 1 | 1 for a write transfer, 0 for a read |
| req_drive | input | 1 | Drive number for the transfer |
| req_addr | input | 3 | Device register address |
| req_wdata | input | 16 | Write data |
| ata_addr | output | 3 | Device address lines |
| ata_sel_n | output | 1 | Active-low device select |
| ata_rd_n | output | 1 | Active-low read strobe |
| ata_wr_n | output | 1 | Active-low write strobe |
| ata_dout | output | 16 | Write data to the device |
| ata_dout_en | output | 1 | Enable for the write data drivers |
| ata_din | input | 16 | Read data from the device |
| rd_data | output | 16 | Captured read data |
| done | output | 1 | One-clock end-of-transfer pulse |

## Verification
The assertions check the following on every cycle:
- the two strobes are never low together;
- a strobe never falls without at least one clock of select beforehand;
- an active period never exceeds the field's wrapped maximum;
- write data stays stable and enabled under the write strobe;
- `done` lasts one clock and coincides with ready.

The exact phase lengths for each encoding cannot be checked by a property, because they depend on the register contents. Only the directed scenarios show them. The same holds for per-drive selection, the sampling clock for read data, and the isolation of an in-flight transfer from a register write. The bench measures these by counting clocks at the pins.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

   typedef enum logic [1:0] {
      PH_IDLE    = 2'd0,
      PH_SETUP   = 2'd1,
      PH_ACTIVE  = 2'd2,
      PH_RECOVER = 2'd3
   } pio_phase_e;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/pio_count_decode.sv
module pio_count_decode #(
   parameter int W     = 3,
   parameter int OUT_W = W + 1
) (
   input  logic [W-1:0]     field,
   output logic [OUT_W-1:0] clocks
);

   localparam logic [OUT_W-1:0] FULL = OUT_W'(1) << W;

   if (OUT_W < W + 1) begin : g_bad_width
      $error("pio_count_decode: OUT_W must hold 2**W");
   end

   always_comb begin
      if (field == '0) clocks = FULL;
      else             clocks = OUT_W'(field);
   end

endmodule

// File: rtl/pio_timing_regs.sv
module pio_timing_regs #(
   parameter int SETUP_W = 3,
   parameter int ACT_W   = 3,
   parameter int REC_W   = 4,
   parameter int DRIVES  = 2,
   parameter int CA_W    = 2,
   parameter int CFG_W   = 7
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cfg_we,
   input  logic [CA_W-1:0]         cfg_addr,
   input  logic [CFG_W-1:0]        cfg_wdata,
   output logic [SETUP_W-1:0]      setup_field,
   output logic [DRIVES*ACT_W-1:0] act_fields,
   output logic [DRIVES*REC_W-1:0] rec_fields
);

   if (CFG_W < ACT_W + REC_W || CFG_W < SETUP_W) begin : g_bad_cfg
      $error("pio_timing_regs: CFG_W too narrow for the fields");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         setup_field <= '0;
      else if (cfg_we && cfg_addr == CA_W'(0))
         setup_field <= cfg_wdata[SETUP_W-1:0];
   end

   for (genvar d = 0; d < DRIVES; d++) begin : g_drive
      logic [ACT_W-1:0] act_q;
      logic [REC_W-1:0] rec_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            act_q <= '0;
            rec_q <= '0;
         end else if (cfg_we && cfg_addr == CA_W'(d + 1)) begin
            act_q <= cfg_wdata[REC_W +: ACT_W];
            rec_q <= cfg_wdata[REC_W-1:0];
         end
      end
      assign act_fields[d*ACT_W +: ACT_W] = act_q;
      assign rec_fields[d*REC_W +: REC_W] = rec_q;
   end

endmodule

// File: rtl/pio_cycle_seq.sv
module pio_cycle_seq
   import ata_pio_pkg::*;
#(
   parameter int CNT_W   = 5,
   parameter int ADDR_W  = 3,
   parameter int DATA_W  = 16,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              start_write,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [DATA_W-1:0] start_wdata,
   input  logic [CNT_W-1:0]  setup_clks,
   input  logic [CNT_W-1:0]  act_clks,
   input  logic [CNT_W-1:0]  rec_clks,
   input  logic [DATA_W-1:0] ata_din,
   output logic              idle,
   output logic              ata_sel_n,
   output logic              ata_rd_n,
   output logic              ata_wr_n,
   output logic [ADDR_W-1:0] ata_addr,
   output logic [DATA_W-1:0] ata_dout,
   output logic              ata_dout_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              done
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   pio_phase_e       phase_q, phase_n;
   logic [CNT_W-1:0] cnt_q, cnt_n;
   logic [CNT_W-1:0] act_q, rec_q;
   logic             wr_q, wr_n;
   logic             last_clk, capture, finish;

   assign last_clk = (cnt_q == '0);
   assign wr_n     = start ? start_write : wr_q;

   always_comb begin
      phase_n = phase_q;
      cnt_n   = cnt_q;
      capture = 1'b0;
      finish  = 1'b0;
      unique case (phase_q)
         PH_IDLE: begin
            if (start) begin
               phase_n = PH_SETUP;
               cnt_n   = setup_clks - ONE;
            end
         end
         PH_SETUP: begin
            if (last_clk) begin
               phase_n = PH_ACTIVE;
               cnt_n   = act_q - ONE;
            end else begin
               cnt_n = cnt_q - ONE;
            end
         end
         PH_ACTIVE: begin
            if (last_clk) begin
               phase_n = PH_RECOVER;
               cnt_n   = rec_q - ONE;
               capture = ~wr_q;
            end else begin
               cnt_n = cnt_q - ONE;
            end
         end
         PH_RECOVER: begin
            if (last_clk) begin
               phase_n = PH_IDLE;
               finish  = 1'b1;
            end else begin
               cnt_n = cnt_q - ONE;
            end
         end
         default: phase_n = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         act_q   <= '0;
         rec_q   <= '0;
         wr_q    <= 1'b0;
         done    <= 1'b0;
      end else begin
         phase_q <= phase_n;
         cnt_q   <= cnt_n;
         wr_q    <= wr_n;
         done    <= finish;
         if (start) begin
            act_q <= act_clks;
            rec_q <= rec_clks;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ata_addr <= '0;
         ata_dout <= '0;
         rd_data  <= '0;
      end else begin
         if (start) begin
            ata_addr <= start_addr;
            ata_dout <= start_wdata;
         end
         if (capture) rd_data <= ata_din;
      end
   end

   assign idle = (phase_q == PH_IDLE);

   if (OUT_REG) begin : g_out_reg
      logic sel_n_q, rd_n_q, wr_n_q, oe_q;
      logic sel_nx, strobe_nx;
      assign sel_nx    = (phase_n == PH_SETUP) || (phase_n == PH_ACTIVE);
      assign strobe_nx = (phase_n == PH_ACTIVE);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sel_n_q <= 1'b1;
            rd_n_q  <= 1'b1;
            wr_n_q  <= 1'b1;
            oe_q    <= 1'b0;
         end else begin
            sel_n_q <= ~sel_nx;
            rd_n_q  <= ~(strobe_nx & ~wr_n);
            wr_n_q  <= ~(strobe_nx & wr_n);
            oe_q    <= sel_nx & wr_n;
         end
      end
      assign ata_sel_n   = sel_n_q;
      assign ata_rd_n    = rd_n_q;
      assign ata_wr_n    = wr_n_q;
      assign ata_dout_en = oe_q;
   end else begin : g_out_comb
      logic sel_on, strobe_on;
      assign sel_on      = (phase_q == PH_SETUP) || (phase_q == PH_ACTIVE);
      assign strobe_on   = (phase_q == PH_ACTIVE);
      assign ata_sel_n   = ~sel_on;
      assign ata_rd_n    = ~(strobe_on & ~wr_q);
      assign ata_wr_n    = ~(strobe_on & wr_q);
      assign ata_dout_en = sel_on & wr_q;
   end

endmodule

// File: rtl/ata_pio_timer.sv
module ata_pio_timer
   import ata_pio_pkg::*;
#(
   parameter int SETUP_W = 3,
   parameter int ACT_W   = 3,
   parameter int REC_W   = 4,
   parameter int DRIVES  = 2,
   parameter int ADDR_W  = 3,
   parameter int DATA_W  = 16,
   parameter bit OUT_REG = 1'b1,
   localparam int CA_W   = $clog2(DRIVES + 1),
   localparam int DRV_W  = (DRIVES > 1) ? $clog2(DRIVES) : 1,
   localparam int CFG_W  = ((ACT_W + REC_W) > SETUP_W) ? (ACT_W + REC_W) : SETUP_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CA_W-1:0]   cfg_addr,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [DRV_W-1:0]  req_drive,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [ADDR_W-1:0] ata_addr,
   output logic              ata_sel_n,
   output logic              ata_rd_n,
   output logic              ata_wr_n,
   output logic [DATA_W-1:0] ata_dout,
   output logic              ata_dout_en,
   input  logic [DATA_W-1:0] ata_din,
   output logic [DATA_W-1:0] rd_data,
   output logic              done
);

   localparam int CNT_W = max3(SETUP_W, ACT_W, REC_W) + 1;

   if (DRIVES < 1 || SETUP_W < 1 || ACT_W < 1 || REC_W < 1) begin : g_bad_param
      $error("ata_pio_timer: counts and drive number must be positive");
   end

   logic [SETUP_W-1:0]      setup_field;
   logic [DRIVES*ACT_W-1:0] act_fields;
   logic [DRIVES*REC_W-1:0] rec_fields;
   logic [ACT_W-1:0]        act_sel;
   logic [REC_W-1:0]        rec_sel;
   logic [CNT_W-1:0]        setup_clks, act_clks, rec_clks;
   logic                    idle, start;

   pio_timing_regs #(
      .SETUP_W(SETUP_W), .ACT_W(ACT_W), .REC_W(REC_W),
      .DRIVES(DRIVES), .CA_W(CA_W), .CFG_W(CFG_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .setup_field(setup_field),
      .act_fields(act_fields), .rec_fields(rec_fields)
   );

   if (DRIVES > 1) begin : g_multi
      assign act_sel = act_fields[req_drive*ACT_W +: ACT_W];
      assign rec_sel = rec_fields[req_drive*REC_W +: REC_W];
   end else begin : g_single
      logic unused_drv;
      assign unused_drv = ^req_drive;
      assign act_sel    = act_fields;
      assign rec_sel    = rec_fields;
   end

   pio_count_decode #(.W(SETUP_W), .OUT_W(CNT_W)) u_dec_setup (
      .field(setup_field), .clocks(setup_clks));
   pio_count_decode #(.W(ACT_W), .OUT_W(CNT_W)) u_dec_act (
      .field(act_sel), .clocks(act_clks));
   pio_count_decode #(.W(REC_W), .OUT_W(CNT_W)) u_dec_rec (
      .field(rec_sel), .clocks(rec_clks));

   assign req_ready = idle;
   assign start     = req_valid & idle;

   pio_cycle_seq #(
      .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OUT_REG(OUT_REG)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .start_write(req_write),
      .start_addr(req_addr), .start_wdata(req_wdata),
      .setup_clks(setup_clks), .act_clks(act_clks), .rec_clks(rec_clks),
      .ata_din(ata_din), .idle(idle), .ata_sel_n(ata_sel_n),
      .ata_rd_n(ata_rd_n), .ata_wr_n(ata_wr_n), .ata_addr(ata_addr),
      .ata_dout(ata_dout), .ata_dout_en(ata_dout_en), .rd_data(rd_data),
      .done(done)
   );

endmodule

// File: rtl/ata_pio_timer_chk.sv
module ata_pio_timer_chk #(
   parameter int ACT_W  = 3,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              ata_sel_n,
   input logic              ata_rd_n,
   input logic              ata_wr_n,
   input logic [DATA_W-1:0] ata_dout,
   input logic              ata_dout_en,
   input logic              done
);

   localparam int RUN_W = ACT_W + 2;
   localparam logic [RUN_W-1:0] ACT_MAX = RUN_W'(1) << ACT_W;

   logic             strobe_any_n;
   logic [RUN_W-1:0] strobe_run;

   assign strobe_any_n = ata_rd_n & ata_wr_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             strobe_run <= '0;
      else if (strobe_any_n)  strobe_run <= '0;
      else if (strobe_run != '1) strobe_run <= strobe_run + RUN_W'(1);
   end

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      ata_rd_n || ata_wr_n);                                        // R2
   AST_SETUP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(strobe_any_n) |-> $past(!ata_sel_n));                   // R1
   AST_ACTIVE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_run <= ACT_MAX);                                       // R2
   AST_ACCEPT_START: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (!ata_sel_n && !req_ready));      // R5
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (ata_sel_n && strobe_any_n && !ata_dout_en));    // R5
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                              // R6
   AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> req_ready);                                          // R6
   AST_WR_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      !ata_wr_n |-> ata_dout_en);                                   // R7
   AST_DOUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (ata_dout_en && $past(ata_dout_en)) |-> $stable(ata_dout));   // R7

endmodule

bind ata_pio_timer ata_pio_timer_chk #(.ACT_W(ACT_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .ata_sel_n(ata_sel_n), .ata_rd_n(ata_rd_n), .ata_wr_n(ata_wr_n),
   .ata_dout(ata_dout), .ata_dout_en(ata_dout_en), .done(done)
);

// File: tb/ata_pio_timer_bench.sv
`timescale 1ns/1ps
module ata_pio_timer_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_addr = '0;
   logic [6:0]  cfg_wdata = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [0:0]  req_drive = '0;
   logic [2:0]  req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [2:0]  ata_addr;
   logic        ata_sel_n, ata_rd_n, ata_wr_n, ata_dout_en, done;
   logic [15:0] ata_dout, rd_data;
   logic [15:0] ata_din = '0;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   ata_pio_timer u_ata_pio_timer (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_drive(req_drive), .req_addr(req_addr),
      .req_wdata(req_wdata), .ata_addr(ata_addr), .ata_sel_n(ata_sel_n),
      .ata_rd_n(ata_rd_n), .ata_wr_n(ata_wr_n), .ata_dout(ata_dout),
      .ata_dout_en(ata_dout_en), .ata_din(ata_din), .rd_data(rd_data),
      .done(done)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [1:0] a, input logic [6:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // One transfer, measured at the pins on falling edges.
   task automatic run_cycle(input bit wr, input logic [0:0] drv, input logic [2:0] a,
                            input logic [15:0] d, input int es, input int ea,
                            input int er, input bit mid, input logic [6:0] mid_val);
      int s = 0, ac = 0, r = 0, guard = 0;
      bit seen_done = 0, bad_sel = 0, bad_data = 0, bad_rdy = 0, bad_str = 0, bad_rec = 0;
      @(negedge clk);
      chk(req_ready, "R5", "ready before request", req_ready, 1);
      req_valid = 1'b1; req_write = wr; req_drive = drv; req_addr = a; req_wdata = d;
      ata_din = 16'h1111;
      @(negedge clk);
      req_valid = 1'b0; req_wdata = ~d; req_addr = ~a;
      while (!seen_done && guard < 200) begin
         cfg_we = 1'b0;
         if (done) begin
            seen_done = 1'b1;
         end else begin
            if (req_ready) bad_rdy = 1'b1;
            if (ata_addr != a) bad_rec = 1'b1;
            if (!ata_rd_n || !ata_wr_n) begin
               ac++;
               if ((wr && !ata_rd_n) || (!wr && !ata_wr_n)) bad_str = 1'b1;
               if (ata_sel_n) bad_sel = 1'b1;
               if (wr && (!ata_dout_en || ata_dout != d)) bad_data = 1'b1;
               if (!wr) ata_din = (ac == ea) ? d : 16'h1111;
               if (mid && ac == 1) begin
                  cfg_we = 1'b1; cfg_addr = {1'b0, drv} + 2'd1; cfg_wdata = mid_val;
               end
            end else if (ac == 0) begin
               s++;
               if (ata_sel_n) bad_sel = 1'b1;
               if (wr && (!ata_dout_en || ata_dout != d)) bad_data = 1'b1;
            end else begin
               r++;
               if (!ata_sel_n || ata_dout_en) bad_rec = 1'b1;
               if (!wr) ata_din = 16'h3333;
            end
            @(negedge clk);
         end
         guard++;
      end
      cfg_we = 1'b0;
      chk(seen_done, "R6", "done seen", seen_done, 1);
      chk(s == es, "R1", "setup clocks", s, es);
      chk(ac == ea, "R2", "active clocks", ac, ea);
      chk(r == er, "R3", "recovery clocks", r, er);
      chk(!bad_sel, "R2", "select during setup/active", bad_sel, 0);
      chk(!bad_str, "R2", "strobe matches direction", bad_str, 0);
      chk(!bad_rec, "R3", "recovery pins and held address", bad_rec, 0);
      chk(!bad_rdy, "R5", "ready low while busy", bad_rdy, 0);
      chk(req_ready, "R6", "ready with done", req_ready, 1);
      if (wr) chk(!bad_data, "R7", "write data setup to active", bad_data, 0);
      else    chk(rd_data == d, "R8", "read data from last active clock", rd_data, d);
      @(negedge clk);
      chk(!done, "R6", "done one clock", done, 0);
      if (!wr) chk(rd_data == d, "R8", "read data held", rd_data, d);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(req_ready && ata_sel_n && ata_rd_n && ata_wr_n && !done && !ata_dout_en,
          "R10", "idle outputs after reset",
          {req_ready, ata_sel_n, ata_rd_n, ata_wr_n, done, ata_dout_en}, 6'b111100);
      run_cycle(1'b0, 1'b0, 3'd7, 16'hA5C3, 8, 8, 16, 1'b0, '0);   // R10
      run_cycle(1'b1, 1'b1, 3'd2, 16'h0F0F, 8, 8, 16, 1'b0, '0);   // R10
   endtask

   task automatic t_fields();
      cfg_write(2'd0, 7'h03);
      cfg_write(2'd1, 7'h25);
      run_cycle(1'b1, 1'b0, 3'd1, 16'h1234, 3, 2, 5, 1'b0, '0);    // R1 R2 R3 R7
      cfg_write(2'd0, 7'h07);
      cfg_write(2'd2, 7'h70);
      run_cycle(1'b0, 1'b1, 3'd5, 16'hBEEF, 7, 7, 16, 1'b0, '0);   // R3 wrap
      cfg_write(2'd0, 7'h78);                                        // setup bits [2:0] = 0
      cfg_write(2'd2, 7'h0F);
      run_cycle(1'b1, 1'b1, 3'd3, 16'h8001, 8, 8, 15, 1'b0, '0);   // R1 R2 wrap
   endtask

   task automatic t_drive_select();
      cfg_write(2'd0, 7'h02);
      cfg_write(2'd1, 7'h11);
      cfg_write(2'd2, 7'h34);
      run_cycle(1'b0, 1'b1, 3'd4, 16'h5A5A, 2, 3, 4, 1'b0, '0);    // R4
      run_cycle(1'b1, 1'b0, 3'd6, 16'hC3C3, 2, 1, 1, 1'b0, '0);    // R4
      cfg_write(2'd3, 7'h7F);                                        // unused address
      run_cycle(1'b0, 1'b1, 3'd0, 16'h0001, 2, 3, 4, 1'b0, '0);    // R4
   endtask

   task automatic t_midwrite();
      cfg_write(2'd0, 7'h02);
      cfg_write(2'd1, 7'h23);
      run_cycle(1'b0, 1'b0, 3'd2, 16'h7E7E, 2, 2, 3, 1'b1, 7'h7F); // R9
      run_cycle(1'b1, 1'b0, 3'd2, 16'h4242, 2, 7, 15, 1'b0, '0);   // R9
   endtask

   task automatic t_modes();
      int st[5] = '{70, 50, 30, 30, 25};
      int at[5] = '{165, 125, 100, 80, 70};
      int ct[5] = '{600, 383, 240, 180, 120};
      for (int m = 0; m < 5; m++) begin
         int s_f, a_f, r_f;
         s_f = (st[m] * 33 + 999) / 1000; if (s_f >= 8) s_f = 0;
         a_f = (at[m] * 33 + 999) / 1000; if (a_f >= 8) a_f = 0;
         r_f = (ct[m] * 33 + 999) / 1000 - a_f - s_f;
         if (r_f == 0) r_f = 1; else if (r_f >= 16) r_f = 0;
         cfg_write(2'd0, 7'(s_f));
         cfg_write(2'd1 + 2'(m % 2), 7'((a_f << 4) | r_f));
         run_cycle(1'(m % 2), 1'(m % 2), 3'(m), 16'(16'h0100 * (m + 1) + m),
                   (s_f == 0) ? 8 : s_f, (a_f == 0) ? 8 : a_f,
                   (r_f == 0) ? 16 : r_f, 1'b0, '0);                // R11
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_fields();
      t_drive_select();
      t_midwrite();
      t_modes();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

endmodule